// File: doc/BRIEF.md
# Stream Ingress Packet Framer

This block sits at the entry of a device-to-host data path. It takes a streaming source with a valid/ready handshake (data, byte enables, stream identifier, end marker and a sideband user word) and hands each accepted beat to a downstream write engine. Each output beat is annotated with a start flag, an end flag, a count of valid bytes, the stream identifier and an error field.

The sideband word is decoded according to two parameters. The first selects whether its lowest bit marks the start of a packet. The second sets how many error bits it carries. Error bits are taken only from the final beat of a packet. The block also checks that the byte enables form a contiguous run beginning at byte 0. It checks that packet starts and ends alternate properly, and it marks any beat that breaks either rule.

A one-entry skid register decouples the input ready from the downstream ready. The input ready is a registered signal, so it never depends combinationally on input valid.

Top module: `axis_ingress_framer`

## Requirements
- R1: A beat transfers only when `s_tvalid` and `s_tready` are both high. While `m_valid` is high and `m_ready` is low, every output holds its value. `s_tready` falls only when a second beat is held in the skid register. Beats leave in the order they arrived, with none lost or repeated.
- R2: `m_nbytes` equals the number of consecutive ones in the byte-enable word, counted upward from bit 0.
- R3: `m_keep_err` is 1 when the byte-enable word is not of the form 2^n-1 with n ≥ 1. This covers a gap, a clear bit 0, and an all-zero word.
- R4: With start mapping on (`SOP_MAP`=1), `m_sop` equals `s_tuser[0]`. `m_frame_err` is 1 when `s_tuser[0]` is high while a packet is open, or low while no packet is open.
- R5: With start mapping off, `m_sop` is 1 on the first beat after reset or after a beat with `s_tlast` high, and 0 otherwise. `m_frame_err` stays 0.
- R6: `m_err` carries `s_tuser[ERR_W:1]` (mapping on) or `s_tuser[ERR_W-1:0]` (mapping off) on a beat with `s_tlast` high. It is 0 on every other beat, whatever the user bits hold.
- R7: `m_eop` equals the input `s_tlast`. `m_data` and `m_id` equal the input data and stream identifier of the same beat.
- R8: A low `rst_n` sampled at a clock edge clears `m_valid` and all output fields, sets `s_tready` to 1, and closes any open packet.
- R9: A beat accepted while the output slot is empty or being drained appears on the outputs with `m_valid` high on the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| s_tvalid | input | 1 | Source beat valid |
| s_tready | output | 1 | Block can take a beat |
| s_tdata | input | DATA_W | Beat data |
| s_tkeep | input | DATA_W/8 | Byte enables |
| s_tid | input | ID_W | Stream identifier |
| s_tlast | input | 1 | Last beat of packet |
| s_tuser | input | ERR_W+SOP_MAP | Start bit (optional) and error bits |
| m_valid | output | 1 | Output beat valid |
| m_ready | input | 1 | Downstream can take a beat |
| m_data | output | DATA_W | Beat data |
| m_id | output | ID_W | Stream identifier |
| m_sop | output | 1 | First beat of packet |
| m_eop | output | 1 | Last beat of packet |
| m_nbytes | output | clog2(DATA_W/8+1) | Valid byte count |
| m_err | output | max(ERR_W,1) | Packet error bits, end beat only |
| m_keep_err | output | 1 | Byte enables not contiguous from byte 0 |
| m_frame_err | output | 1 | Start marker out of place |

## Verification
The hardest state to reach is the skid register holding a beat. It fills only when the output slot is stalled and a new beat is accepted in the same cycle. The stimulus holds `m_ready` low across two accepted beats and keeps a third beat waiting while `s_tready` is low. It then releases `m_ready` and checks that the beats drain in order and that the waiting beat enters only after the skid register empties. A second hard state is an open packet cut by reset. The stimulus opens a packet, pulses reset, and then sends a marked start beat that must not be flagged.

// File: rtl/axis_ingress_framer.sv
`timescale 1ns/1ps
module axis_ingress_framer #(
  parameter int DATA_W  = 32,
  parameter int ID_W    = 1,
  parameter int SOP_MAP = 1,
  parameter int ERR_W   = 3,
  localparam int KEEP_W = DATA_W / 8,
  localparam int USER_W = ERR_W + SOP_MAP,
  localparam int EW_O   = (ERR_W > 0) ? ERR_W : 1,
  localparam int NB_W   = $clog2(KEEP_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              s_tvalid,
  output logic              s_tready,
  input  logic [DATA_W-1:0] s_tdata,
  input  logic [KEEP_W-1:0] s_tkeep,
  input  logic [ID_W-1:0]   s_tid,
  input  logic              s_tlast,
  input  logic [USER_W-1:0] s_tuser,
  output logic              m_valid,
  input  logic              m_ready,
  output logic [DATA_W-1:0] m_data,
  output logic [ID_W-1:0]   m_id,
  output logic              m_sop,
  output logic              m_eop,
  output logic [NB_W-1:0]   m_nbytes,
  output logic [EW_O-1:0]   m_err,
  output logic              m_keep_err,
  output logic              m_frame_err
);
  localparam int BEAT_W = DATA_W + ID_W + EW_O + NB_W + 4;

  logic              open_q;
  logic              sk_valid;
  logic [BEAT_W-1:0] sk_beat, out_beat, in_beat;
  logic [EW_O-1:0]   err_in;
  logic [NB_W-1:0]   nb_in;
  logic              sop_in, fr_in, kerr_in, run;
  logic [KEEP_W:0]   keep_ext, keep_inc;

  wire accept = s_tvalid && s_tready;
  wire drain  = m_ready || !m_valid;

  generate
    if (ERR_W == 0) begin : g_noerr
      assign err_in = '0;
    end else if (SOP_MAP != 0) begin : g_err_hi
      assign err_in = s_tuser[ERR_W:1];
    end else begin : g_err_lo
      assign err_in = s_tuser[ERR_W-1:0];
    end
    if (SOP_MAP != 0) begin : g_sop_map
      assign sop_in = s_tuser[0];
      assign fr_in  = (s_tuser[0] == open_q);
    end else begin : g_sop_auto
      assign sop_in = !open_q;
      assign fr_in  = 1'b0;
    end
  endgenerate

  always_comb begin
    nb_in = '0;
    run   = 1'b1;
    for (int i = 0; i < KEEP_W; i++) begin
      run   = run & s_tkeep[i];
      nb_in = nb_in + NB_W'(run);
    end
  end

  assign keep_ext = {1'b0, s_tkeep};
  assign keep_inc = keep_ext + 1'b1;
  assign kerr_in  = !s_tkeep[0] || ((keep_ext & keep_inc) != '0);

  assign in_beat = {s_tdata, s_tid, (s_tlast ? err_in : EW_O'(0)), nb_in,
                    sop_in, s_tlast, kerr_in, fr_in};

  assign {m_data, m_id, m_err, m_nbytes, m_sop, m_eop, m_keep_err, m_frame_err} = out_beat;
  assign s_tready = !sk_valid;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      open_q   <= 1'b0;
      m_valid  <= 1'b0;
      sk_valid <= 1'b0;
      out_beat <= '0;
      sk_beat  <= '0;
    end else begin
      if (accept) open_q <= !s_tlast;
      if (drain) begin
        if (sk_valid) begin
          out_beat <= sk_beat;
          m_valid  <= 1'b1;
          sk_valid <= 1'b0;
        end else if (accept) begin
          out_beat <= in_beat;
          m_valid  <= 1'b1;
        end else begin
          m_valid  <= 1'b0;
        end
      end else if (accept) begin
        sk_beat  <= in_beat;
        sk_valid <= 1'b1;
      end
    end
  end
endmodule

module axis_ingress_framer_chk #(
  parameter int DATA_W = 32,
  parameter int ID_W   = 1,
  parameter int EW_O   = 3,
  parameter int NB_W   = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              s_tvalid,
  input logic              s_tready,
  input logic              m_valid,
  input logic              m_ready,
  input logic [DATA_W-1:0] m_data,
  input logic [ID_W-1:0]   m_id,
  input logic              m_eop,
  input logic              m_sop,
  input logic [NB_W-1:0]   m_nbytes,
  input logic [EW_O-1:0]   m_err,
  input logic              m_keep_err
);
  // R1
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_ready) |=> (m_valid && $stable(m_data) && $stable(m_id) &&
                               $stable(m_sop) && $stable(m_eop) && $stable(m_err)));
  // R1
  skid_only_when_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !s_tready |-> m_valid);
  // R6
  err_only_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_eop) |-> (m_err == '0));
  // R2
  good_keep_has_bytes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_keep_err) |-> (m_nbytes != '0));
  // R9
  accept_shows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (s_tvalid && s_tready && (m_ready || !m_valid)) |=> m_valid);
endmodule

bind axis_ingress_framer axis_ingress_framer_chk #(
  .DATA_W(DATA_W), .ID_W(ID_W), .EW_O(EW_O), .NB_W(NB_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .s_tvalid(s_tvalid), .s_tready(s_tready),
  .m_valid(m_valid), .m_ready(m_ready), .m_data(m_data), .m_id(m_id),
  .m_eop(m_eop), .m_sop(m_sop), .m_nbytes(m_nbytes), .m_err(m_err),
  .m_keep_err(m_keep_err)
);

// File: tb/test_axis_ingress_framer.sv
`timescale 1ns/1ps
module test_axis_ingress_framer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        s_tvalid = 1'b0, v2 = 1'b0, m_ready = 1'b1;
  logic [31:0] s_tdata = '0;
  logic [3:0]  s_tkeep = '0;
  logic        s_tid = 1'b0, s_tlast = 1'b0;
  logic [3:0]  s_tuser = '0;
  logic [1:0]  u2 = '0;
  logic        s_tready, m_valid, m_id, m_sop, m_eop, m_keep_err, m_frame_err;
  logic [31:0] m_data;
  logic [2:0]  m_nbytes, m_err;
  logic        r2, mv2, id2, sop2, eop2, ke2, fe2;
  logic [31:0] d2;
  logic [2:0]  nb2;
  logic [1:0]  e2;
  int          tests = 0, fails = 0;

  always #4 clk = ~clk;

  axis_ingress_framer #(.DATA_W(32), .ID_W(1), .SOP_MAP(1), .ERR_W(3)) i_axis_ingress_framer (
    .clk(clk), .rst_n(rst_n), .s_tvalid(s_tvalid), .s_tready(s_tready), .s_tdata(s_tdata),
    .s_tkeep(s_tkeep), .s_tid(s_tid), .s_tlast(s_tlast), .s_tuser(s_tuser),
    .m_valid(m_valid), .m_ready(m_ready), .m_data(m_data), .m_id(m_id), .m_sop(m_sop),
    .m_eop(m_eop), .m_nbytes(m_nbytes), .m_err(m_err), .m_keep_err(m_keep_err),
    .m_frame_err(m_frame_err));

  axis_ingress_framer #(.DATA_W(32), .ID_W(1), .SOP_MAP(0), .ERR_W(2)) i_auto (
    .clk(clk), .rst_n(rst_n), .s_tvalid(v2), .s_tready(r2), .s_tdata(s_tdata),
    .s_tkeep(s_tkeep), .s_tid(s_tid), .s_tlast(s_tlast), .s_tuser(u2),
    .m_valid(mv2), .m_ready(1'b1), .m_data(d2), .m_id(id2), .m_sop(sop2),
    .m_eop(eop2), .m_nbytes(nb2), .m_err(e2), .m_keep_err(ke2), .m_frame_err(fe2));

  // {keep, last, user, exp_sop, exp_eop, exp_nb, exp_err, exp_keep_err, exp_frame_err}
  localparam logic [18:0] VEC [11] = '{
    {4'hF, 1'b0, 4'b0001, 1'b1, 1'b0, 3'd4, 3'd0, 1'b0, 1'b0},
    {4'hF, 1'b0, 4'b1110, 1'b0, 1'b0, 3'd4, 3'd0, 1'b0, 1'b0},
    {4'h3, 1'b1, 4'b1010, 1'b0, 1'b1, 3'd2, 3'd5, 1'b0, 1'b0},
    {4'h1, 1'b1, 4'b0111, 1'b1, 1'b1, 3'd1, 3'd3, 1'b0, 1'b0},
    {4'h5, 1'b0, 4'b0001, 1'b1, 1'b0, 3'd1, 3'd0, 1'b1, 1'b0},
    {4'hE, 1'b0, 4'b0000, 1'b0, 1'b0, 3'd0, 3'd0, 1'b1, 1'b0},
    {4'hF, 1'b0, 4'b0001, 1'b1, 1'b0, 3'd4, 3'd0, 1'b0, 1'b1},
    {4'h7, 1'b1, 4'b0000, 1'b0, 1'b1, 3'd3, 3'd0, 1'b0, 1'b0},
    {4'hF, 1'b0, 4'b0000, 1'b0, 1'b0, 3'd4, 3'd0, 1'b0, 1'b1},
    {4'h0, 1'b1, 4'b1110, 1'b0, 1'b1, 3'd0, 3'd7, 1'b1, 1'b0},
    {4'h1, 1'b1, 4'b0001, 1'b1, 1'b1, 3'd1, 3'd0, 1'b0, 1'b0}
  };

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic beat(input logic [31:0] d, input logic [3:0] k, input logic l, input logic [3:0] u);
    s_tvalid = 1'b1; s_tdata = d; s_tkeep = k; s_tlast = l; s_tuser = u; s_tid = d[0];
  endtask

  initial begin
    #(8 * 150000);
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R8 reset m_valid", 64'(m_valid), 0);
    check("R8 reset s_tready", 64'(s_tready), 1);
    check("R8 reset fields", 64'({m_data, m_sop, m_eop, m_err, m_nbytes}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    for (int i = 0; i < 11; i++) begin
      beat(32'hA500_0000 | 32'(i), VEC[i][18:15], VEC[i][14], VEC[i][13:10]);
      @(negedge clk);
      check("R9 valid next cycle", 64'(m_valid), 1);
      check("R7 data/id/eop", 64'({m_data, m_id, m_eop}), 64'({32'hA500_0000 | 32'(i), i[0], VEC[i][8]}));
      check("R4 sop", 64'(m_sop), 64'(VEC[i][9]));
      check("R2 nbytes", 64'(m_nbytes), 64'(VEC[i][7:5]));
      check("R6 err", 64'(m_err), 64'(VEC[i][4:2]));
      check("R3 keep_err", 64'(m_keep_err), 64'(VEC[i][1]));
      check("R4 frame_err", 64'(m_frame_err), 64'(VEC[i][0]));
    end
    s_tvalid = 1'b0;
    @(negedge clk);
    check("R1 idle no valid", 64'(m_valid), 0);

    // R5 / R6 with start mapping off
    v2 = 1'b1; s_tdata = 32'h11; s_tkeep = 4'hF; s_tlast = 1'b0; u2 = 2'b11;
    @(negedge clk);
    check("R5 first beat sop", 64'({sop2, e2, fe2}), 64'({1'b1, 2'b00, 1'b0}));
    s_tdata = 32'h22; s_tlast = 1'b1; u2 = 2'b10;
    @(negedge clk);
    check("R5 mid sop low, R6 err lo bits", 64'({sop2, eop2, e2}), 64'({1'b0, 1'b1, 2'b10}));
    s_tdata = 32'h33; s_tkeep = 4'h3; u2 = 2'b01;
    @(negedge clk);
    check("R5 sop after last", 64'({sop2, nb2, e2, d2}), 64'({1'b1, 3'd2, 2'b01, 32'h33}));
    v2 = 1'b0;

    // R1 backpressure through the skid register
    m_ready = 1'b0;
    beat(32'hAAAA, 4'hF, 1'b0, 4'b0001);
    @(negedge clk);
    check("R1 first held", 64'({m_valid, m_data, s_tready}), 64'({1'b1, 32'hAAAA, 1'b1}));
    beat(32'hBBBB, 4'h3, 1'b1, 4'b0000);
    @(negedge clk);
    check("R1 skid full", 64'({s_tready, m_data}), 64'({1'b0, 32'hAAAA}));
    beat(32'hCCCC, 4'h1, 1'b1, 4'b0001);
    @(negedge clk);
    check("R1 stalled stable", 64'({s_tready, m_data, m_sop}), 64'({1'b0, 32'hAAAA, 1'b1}));
    m_ready = 1'b1;
    @(negedge clk);
    check("R1 skid drains in order", 64'({m_data, m_eop, m_nbytes, s_tready}), 64'({32'hBBBB, 1'b1, 3'd2, 1'b1}));
    @(negedge clk);
    check("R1 waiting beat enters", 64'({m_data, m_sop}), 64'({32'hCCCC, 1'b1}));
    s_tvalid = 1'b0;
    @(negedge clk);
    check("R1 no duplicate", 64'(m_valid), 0);

    // R8 reset closes an open packet
    beat(32'hD0, 4'hF, 1'b0, 4'b0001);
    @(negedge clk);
    s_tvalid = 1'b0; rst_n = 1'b0;
    repeat (2) @(negedge clk);
    check("R8 reset mid packet", 64'(m_valid), 0);
    rst_n = 1'b1;
    beat(32'hD1, 4'hF, 1'b1, 4'b0001);
    @(negedge clk);
    check("R8 packet closed by reset", 64'({m_valid, m_sop, m_frame_err}), 64'({1'b1, 1'b1, 1'b0}));
    s_tvalid = 1'b0;
    @(negedge clk);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule